// File: doc/BRIEF.md
# Interframe Gap Timer

This block measures the quiet time a serial link transmitter must leave between frames. Software writes an 8-bit spacing value in bit times. The block keeps half of that value as a 7-bit count. On a start strobe the count is loaded and runs down to zero twice, one step per bit-time tick. The one-cycle `gapDone` pulse then tells the transmitter it may send again.

The readback port is live and purely combinational. It carries the running count in its upper seven bits and a phase flag in bit 0. The phase flag is 1 during the first pass and 0 during the second. A stored value of zero makes each pass wrap through all 128 count values, which gives 256 bit times.

While a gap is running, a reappearing carrier restarts the timer. When the deterministic collision resolution mode input is high, a reappearing carrier is ignored.

Top module: `gap_spacing_timer`

## Requirements
- R1: After reset `rdData` is 8'h00 and `gapDone` is 0.
- R2: A write stores `wrData[7:1]` as the half count and discards `wrData[0]`. A write during a running gap does not change `rdData`.
- R3: A start strobe loads the stored half count H. From the next cycle `rdData` equals {H, 1'b1}, where bits 7..1 hold the count and bit 0 is the phase flag.
- R4: The count decrements by one only in cycles where `bitTick` is high. With no tick, no start and no carrier, `rdData` holds its value.
- R5: On the H-th tick of the first pass, the count reloads to H and the phase flag drops to 0.
- R6: The total gap is 2H ticks. `gapDone` is high for exactly one cycle, in the cycle after the final tick. After that `rdData` is 8'h00, and ticks have no effect until the next start.
- R7: A stored half count of 0 (a written value of 0 or 1) gives 256 ticks, because the count wraps from 0 to 127.
- R8: With `detMode` low, `carrierSeen` during a running gap reloads the count from the stored value and sets the phase flag to 1.
- R9: With `detMode` high, `carrierSeen` has no effect. While the timer is idle, `carrierSeen` has no effect in either mode.
- R10: A start has priority over a tick in the same cycle. A start in the same cycle as a write loads the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit time |
| wrEn | input | 1 | Spacing register write enable |
| wrData | input | 8 | Spacing value in bit times |
| startStrobe | input | 1 | Starts the gap from the stored value |
| carrierSeen | input | 1 | Carrier reappeared on the line |
| detMode | input | 1 | Deterministic collision mode; blocks carrier retrigger |
| rdData | output | 8 | Live count (bits 7..1) and phase flag (bit 0) |
| gapDone | output | 1 | One-cycle pulse when the gap has elapsed |

## Verification
The assertions assume `bitTick` and `startStrobe` are single-cycle pulses from clean synchronous logic. They also assume no input changes during a clock edge. The stimulus meets this by driving every input on the falling edge and holding each strobe for exactly one cycle. Ticks are issued either alone or, on purpose, together with a start or a write, so that the priority cases are exercised.

// File: rtl/gap_timer_pkg.sv
package gap_timer_pkg;
  typedef struct packed {
    logic load;    // start/retrigger: take the half count
    logic reload;  // end of first pass: take stored half count again
    logic dec;     // step the count down by one
  } ctlStrobes_t;
endpackage

// File: rtl/gap_timer_dp.sv
module gap_timer_dp
  import gap_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  ctlStrobes_t       strb,
  output logic              cntIsOne,
  output logic [CNT_W-1:0]  cntValue
);
  logic [CNT_W-1:0] storedHalf;
  logic [CNT_W-1:0] loadSrc;
  logic             unusedLsb;

  assign unusedLsb = wrData[0];
  assign loadSrc   = wrEn ? wrData[DATA_W-1:1] : storedHalf;
  assign cntIsOne  = (cntValue == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedHalf <= '0;
    end else if (wrEn) begin
      storedHalf <= wrData[DATA_W-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntValue <= '0;
    end else if (strb.load) begin
      cntValue <= loadSrc;
    end else if (strb.reload) begin
      cntValue <= storedHalf;
    end else if (strb.dec) begin
      cntValue <= cntValue - CNT_W'(1);
    end
  end

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.reload, strb.dec}));
endmodule

// File: rtl/gap_timer_ctl.sv
module gap_timer_ctl
  import gap_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        startStrobe,
  input  logic        carrierSeen,
  input  logic        detMode,
  input  logic        cntIsOne,
  output ctlStrobes_t strb,
  output logic        phaseBit,
  output logic        gapDone
);
  logic active;
  logic restart;
  logic step;
  logic lastStep;
  logic secondPass;
  logic finish;

  assign restart    = startStrobe | (carrierSeen & active & ~detMode);
  assign step       = active & bitTick & ~restart;
  assign lastStep   = step & cntIsOne;
  assign secondPass = lastStep & phaseBit;
  assign finish     = lastStep & ~phaseBit;

  always_comb begin
    strb.load   = restart;
    strb.reload = secondPass;
    strb.dec    = step & ~secondPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      phaseBit <= 1'b0;
      gapDone  <= 1'b0;
    end else begin
      gapDone <= finish;
      if (restart) begin
        active   <= 1'b1;
        phaseBit <= 1'b1;
      end else if (secondPass) begin
        phaseBit <= 1'b0;
      end else if (finish) begin
        active <= 1'b0;
      end
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapDone |=> !gapDone);
  // R5
  phase_fall_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phaseBit) |-> $past(bitTick));
  // R3
  active_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(startStrobe || carrierSeen));
endmodule

// File: rtl/gap_spacing_timer.sv
module gap_spacing_timer
  import gap_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              startStrobe,
  input  logic              carrierSeen,
  input  logic              detMode,
  output logic [DATA_W-1:0] rdData,
  output logic              gapDone
);
  ctlStrobes_t      strb;
  logic             cntIsOne;
  logic             phaseBit;
  logic [CNT_W-1:0] cntValue;

  gap_timer_ctl u_ctl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startStrobe(startStrobe),
    .carrierSeen(carrierSeen), .detMode(detMode), .cntIsOne(cntIsOne),
    .strb(strb), .phaseBit(phaseBit), .gapDone(gapDone)
  );

  gap_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strb(strb),
    .cntIsOne(cntIsOne), .cntValue(cntValue)
  );

  assign rdData = {cntValue, phaseBit};

  // R4
  hold_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !startStrobe && !carrierSeen) |=> $stable(rdData));
  // R3
  start_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |=> rdData[0]);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapDone |-> (rdData == '0));
endmodule

// File: tb/gap_spacing_timer_test.sv
module gap_spacing_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {written value, expected gap in ticks}
  localparam logic [7:0]  VEC_VAL [NVEC] = '{8'd6, 8'd2, 8'd7, 8'd1, 8'd0, 8'd254, 8'd40};
  localparam int          VEC_LEN [NVEC] = '{6, 2, 6, 256, 256, 254, 40};

  logic clk = 0, rstN = 0, bitTick = 0, wrEn = 0, startStrobe = 0;
  logic carrierSeen = 0, detMode = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic gapDone;
  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  gap_spacing_timer uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn), .wrData(wrData),
    .startStrobe(startStrobe), .carrierSeen(carrierSeen), .detMode(detMode),
    .rdData(rdData), .gapDone(gapDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkRd(input string req, input logic [7:0] exp);
    check(rdData === exp, req, rdData, exp);
  endtask

  // one-cycle pulse set; returns at the falling edge after the consuming edge
  task automatic pulse(input bit t, input bit w, input logic [7:0] d, input bit s, input bit c);
    bitTick = t; wrEn = w; wrData = d; startStrobe = s; carrierSeen = c;
    @(negedge clk);
    bitTick = 0; wrEn = 0; startStrobe = 0; carrierSeen = 0;
  endtask

  task automatic doTick();
    pulse(1, 0, 0, 0, 0);
  endtask

  task automatic runToDone(output int n);
    n = 0;
    for (int i = 1; i <= 300; i++) begin
      doTick();
      if (gapDone) begin n = i; break; end
    end
  endtask

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkRd("R1 reset rdData", 8'h00);
    check(gapDone == 0, "R1 reset gapDone", gapDone, 0);

    pulse(0, 1, 8'd10, 0, 0);
    pulse(0, 0, 0, 1, 0);
    chkRd("R3 start load", 8'h0B);
    repeat (3) @(negedge clk);
    chkRd("R4 hold without tick", 8'h0B);
    doTick();
    chkRd("R4 decrement", 8'h09);
    repeat (4) doTick();
    chkRd("R5 second pass reload", 8'h0A);
    pulse(0, 1, 8'd40, 0, 0);
    chkRd("R2 write during run", 8'h0A);
    doTick();
    chkRd("R4 second pass step", 8'h08);
    pulse(0, 0, 0, 0, 1);
    chkRd("R8 carrier retrigger", 8'h29);
    detMode = 1;
    doTick();
    pulse(0, 0, 0, 0, 1);
    chkRd("R9 carrier ignored in det mode", 8'h27);
    runToDone(n);
    check(n == 39, "R6 remaining gap length", n, 39);
    @(negedge clk);
    check(gapDone == 0, "R6 done single pulse", gapDone, 0);
    chkRd("R6 idle value", 8'h00);
    doTick();
    chkRd("R6 tick while idle", 8'h00);
    check(gapDone == 0, "R6 no done while idle", gapDone, 0);
    detMode = 0;
    pulse(0, 0, 0, 0, 1);
    chkRd("R9 carrier while idle", 8'h00);

    pulse(1, 0, 0, 1, 0);
    chkRd("R10 start beats tick", 8'h29);
    pulse(0, 1, 8'd8, 1, 0);
    chkRd("R10 write with start", 8'h09);

    for (int v = 0; v < NVEC; v++) begin
      pulse(0, 1, VEC_VAL[v], 0, 0);
      pulse(0, 0, 0, 1, 0);
      chkRd("R2 R3 vector load", {VEC_VAL[v][7:1], 1'b1});
      runToDone(n);
      check(n == VEC_LEN[v], (VEC_LEN[v] == 256) ? "R7 zero half gap" : "R6 vector gap", n, VEC_LEN[v]);
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule